// File: doc/BRIEF.md
# Double-Banked Colour Palette

This block turns 8-bit pixel indices into 24-bit RGB colours through a palette of 256 entries held in two banks. One bank feeds the display while the processor rewrites the other; when the new palette is complete the processor flips a request bit, and the banks trade places at the next frame boundary. The swap never happens in the middle of a frame, so the picture cannot show a half-loaded palette.

Software polls a status bit that follows the request bit once the swap has happened. When the two bits match, the hidden bank is free to be rewritten. In direct-colour modes the palette is skipped and the pixel's own 24-bit colour is passed through, with the same latency as a lookup.

Top module: `clutDualBank`

## Requirements
- R1: After reset the control register reads 0 (request bit 0 and status bit 0), bank 0 is the displayed bank and `rgbValid` is low.
- R2: A processor write to byte address 0x400 + 4·n (n in 0..255) stores `cpuWrData[23:0]` into entry n of the bank that is not displayed; what is displayed does not change.
- R3: A processor read is answered on `cpuRdData` one cycle after `cpuRdEn`. An entry address returns that entry of the hidden bank. Address 0x018 returns the request bit in bit 0 and the status bit in bit 1, with zeros above. Any other address returns 0.
- R4: A write to 0x018 loads `cpuWrData[0]` into the request bit. Bit 1 of the write is ignored, and the status bit is not changed by the write.
- R5: The banks swap only on a cycle with `frameStrobe` high while the request bit differs from the status bit. On that edge the status bit takes the request bit's value. A frame strobe while the two bits are equal changes nothing.
- R6: A pixel with `pixValid` high and `lutEnable` high produces `rgbValid` and the displayed bank's entry `pixIdx` on `rgbOut` one cycle later (red in 23:16, green in 15:8, blue in 7:0). `rgbValid` is low in the cycle after `pixValid` is low.
- R7: With `lutEnable` low, `rgbOut` carries `directRgb` one cycle after `pixValid`, and the palette is not used.
- R8: If a control write and a frame strobe fall in the same cycle, the swap decision uses the request bit held before that write.
- R9: An entry write in the same cycle as a swap lands in the bank that was hidden before the edge. That bank is the one displayed after the edge.
- R10: A pixel looked up in the same cycle as a swap uses the bank displayed before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWrEn | input | 1 | Processor write strobe |
| cpuRdEn | input | 1 | Processor read strobe |
| cpuAddr | input | 12 | Processor byte address |
| cpuWrData | input | 24 | Processor write data |
| cpuRdData | output | 24 | Processor read data, one cycle after the strobe |
| frameStrobe | input | 1 | One-cycle pulse at the frame boundary |
| lutEnable | input | 1 | 1: indexed mode through the palette; 0: direct colour |
| pixIdx | input | 8 | Pixel palette index |
| directRgb | input | 24 | Pixel colour used in direct mode |
| pixValid | input | 1 | Pixel input valid |
| rgbOut | output | 24 | Output colour |
| rgbValid | output | 1 | Output colour valid |

## Verification
The risky overlap is a frame strobe that lands in the same cycle as processor traffic. That traffic can be a control write that changes the request bit, an entry write aimed at the hidden bank, or a pixel lookup. The bench drives these together on a single edge. It then judges the outcome from the control register readback, which shows which request value the swap used. It also uses pixel lookups just before and just after the edge, which show which bank each write reached and which bank each lookup read.

// File: rtl/clutPkg.sv
package clutPkg;
  localparam int LUT_IDX_W = 8;
  localparam int LUT_COLOR_W = 24;
  localparam int LUT_ENTRIES = 1 << LUT_IDX_W;

  // strobes and state passed from control to the datapath
  typedef struct packed {
    logic                 entryWr;
    logic                 entryRd;
    logic                 ctrlRd;
    logic                 anyRd;
    logic [LUT_IDX_W-1:0] entryIdx;
    logic                 showBank;
    logic [1:0]           ctrlBits;
  } lutStrobe_t;
endpackage

// File: rtl/clutCtrl.sv
module clutCtrl
  import clutPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LUT_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h018
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              wrBit0,
  input  logic              frameStrobe,
  output lutStrobe_t        stb,
  output logic              switchBit,
  output logic              statusBit
);
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, LUT_BASE};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(4 * LUT_ENTRIES);

  logic inWindow;
  logic isCtrl;
  logic swapNow;

  assign inWindow = ({1'b0, cpuAddr} >= WIN_LO) && ({1'b0, cpuAddr} < WIN_HI);
  assign isCtrl   = (cpuAddr == CTRL_ADDR);
  assign swapNow  = frameStrobe && (switchBit != statusBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      switchBit <= 1'b0;
      statusBit <= 1'b0;
    end else begin
      if (cpuWrEn && isCtrl) switchBit <= wrBit0;
      if (swapNow) statusBit <= switchBit;
    end
  end

  always_comb begin
    stb.entryWr  = cpuWrEn && inWindow;
    stb.entryRd  = cpuRdEn && inWindow;
    stb.ctrlRd   = cpuRdEn && isCtrl;
    stb.anyRd    = cpuRdEn;
    stb.entryIdx = LUT_IDX_W'((cpuAddr - LUT_BASE) >> 2);
    stb.showBank = statusBit;
    stb.ctrlBits = {statusBit, switchBit};
  end
endmodule

// File: rtl/clutStore.sv
module clutStore
  import clutPkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lutStrobe_t             stb,
  input  logic [LUT_COLOR_W-1:0] cpuWrData,
  input  logic [LUT_IDX_W-1:0]   pixIdx,
  input  logic                   pixValid,
  input  logic                   lutEnable,
  input  logic [LUT_COLOR_W-1:0] directRgb,
  output logic [LUT_COLOR_W-1:0] rgbOut,
  output logic                   rgbValid,
  output logic [LUT_COLOR_W-1:0] cpuRdData
);
  logic [LUT_COLOR_W-1:0] pixRd [NUM_BANKS];
  logic [LUT_COLOR_W-1:0] cpuRd [NUM_BANKS];
  logic                   hideBank;

  assign hideBank = !stb.showBank;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [LUT_COLOR_W-1:0] mem [LUT_ENTRIES];
    always_ff @(posedge clk) begin
      if (stb.entryWr && (hideBank == 1'(b))) mem[stb.entryIdx] <= cpuWrData;
    end
    assign pixRd[b] = mem[pixIdx];
    assign cpuRd[b] = mem[stb.entryIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rgbValid <= 1'b0;
      rgbOut   <= '0;
    end else begin
      rgbValid <= pixValid;
      if (pixValid) rgbOut <= lutEnable ? pixRd[stb.showBank] : directRgb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdData <= '0;
    end else if (stb.anyRd) begin
      if (stb.ctrlRd)       cpuRdData <= {{(LUT_COLOR_W-2){1'b0}}, stb.ctrlBits};
      else if (stb.entryRd) cpuRdData <= cpuRd[hideBank];
      else                  cpuRdData <= '0;
    end
  end
endmodule

// File: rtl/clutDualBank.sv
module clutDualBank
  import clutPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LUT_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h018
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuWrEn,
  input  logic                   cpuRdEn,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic [LUT_COLOR_W-1:0] cpuWrData,
  output logic [LUT_COLOR_W-1:0] cpuRdData,
  input  logic                   frameStrobe,
  input  logic                   lutEnable,
  input  logic [LUT_IDX_W-1:0]   pixIdx,
  input  logic [LUT_COLOR_W-1:0] directRgb,
  input  logic                   pixValid,
  output logic [LUT_COLOR_W-1:0] rgbOut,
  output logic                   rgbValid
);
  lutStrobe_t stb;
  logic switchBit;
  logic statusBit;

  clutCtrl #(.ADDR_W(ADDR_W), .LUT_BASE(LUT_BASE), .CTRL_ADDR(CTRL_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuAddr(cpuAddr), .wrBit0(cpuWrData[0]), .frameStrobe(frameStrobe),
    .stb(stb), .switchBit(switchBit), .statusBit(statusBit)
  );

  clutStore #(.NUM_BANKS(2)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWrData(cpuWrData),
    .pixIdx(pixIdx), .pixValid(pixValid), .lutEnable(lutEnable),
    .directRgb(directRgb), .rgbOut(rgbOut), .rgbValid(rgbValid),
    .cpuRdData(cpuRdData)
  );
endmodule

// File: rtl/clutDualBankChk.sv
module clutDualBankChk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h018
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWrEn,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              wrBit0,
  input logic              frameStrobe,
  input logic              lutEnable,
  input logic [23:0]       directRgb,
  input logic              pixValid,
  input logic [23:0]       rgbOut,
  input logic              rgbValid,
  input logic              switchBit,
  input logic              statusBit
);
  // R4: a control write loads the request bit
  assert_switch_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr == CTRL_ADDR) |=> (switchBit == $past(wrBit0)));

  // R5: status moves only at a frame strobe, to the old request value
  assert_swap_at_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusBit) |-> ($past(frameStrobe) && statusBit == $past(switchBit)));

  // R5: a strobe with nothing pending leaves the status alone
  assert_idle_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && switchBit == statusBit) |=> $stable(statusBit));

  // R6: output valid follows input valid by one cycle
  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> rgbValid);
  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !rgbValid);

  // R7: direct colour passes through
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !lutEnable) |=> (rgbOut == $past(directRgb)));
endmodule

bind clutDualBank clutDualBankChk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
  .wrBit0(cpuWrData[0]), .frameStrobe(frameStrobe), .lutEnable(lutEnable),
  .directRgb(directRgb), .pixValid(pixValid), .rgbOut(rgbOut),
  .rgbValid(rgbValid), .switchBit(switchBit), .statusBit(statusBit)
);

// File: tb/sim_clutDualBank.sv
module sim_clutDualBank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [23:0] cpuWrData = '0;
  logic [23:0] cpuRdData;
  logic        frameStrobe = 1'b0, lutEnable = 1'b0, pixValid = 1'b0;
  logic [7:0]  pixIdx = '0;
  logic [23:0] directRgb = '0;
  logic [23:0] rgbOut;
  logic        rgbValid;

  int nChecks = 0;
  int nFails = 0;

  localparam logic [11:0] CTRL = 12'h018;
  localparam logic [23:0] A0 = 24'h102030, A5 = 24'hFF8001, A255 = 24'h00FFAA;
  localparam logic [23:0] B5 = 24'h123456, C7 = 24'hC0FFEE;

  clutDualBank u0 (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .frameStrobe(frameStrobe), .lutEnable(lutEnable), .pixIdx(pixIdx),
    .directRgb(directRgb), .pixValid(pixValid), .rgbOut(rgbOut), .rgbValid(rgbValid)
  );

  function automatic logic [11:0] entryAddr(int n);
    return 12'h400 + 12'(n * 4);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic quiet();
    cpuWrEn = 0; cpuRdEn = 0; frameStrobe = 0; pixValid = 0;
  endtask

  task automatic cpuWrite(logic [11:0] a, logic [23:0] d);
    @(negedge clk); cpuWrEn = 1; cpuAddr = a; cpuWrData = d;
    @(negedge clk); quiet();
  endtask

  task automatic cpuRead(logic [11:0] a, output logic [23:0] d);
    @(negedge clk); cpuRdEn = 1; cpuAddr = a;
    @(negedge clk); quiet(); d = cpuRdData;
  endtask

  task automatic frame();
    @(negedge clk); frameStrobe = 1;
    @(negedge clk); quiet();
  endtask

  task automatic lookup(logic [7:0] idx, logic lut, logic [23:0] dir,
                        output logic [23:0] rgb, output logic vld);
    @(negedge clk); pixValid = 1; pixIdx = idx; lutEnable = lut; directRgb = dir;
    @(negedge clk); quiet(); rgb = rgbOut; vld = rgbValid;
  endtask

  task automatic testReset();
    logic [23:0] d;
    check("R1 rgbValid", 32'(rgbValid), 0);
    cpuRead(CTRL, d);
    check("R1 control", 32'(d), 0);
  endtask

  task automatic testLoadHidden();
    logic [23:0] d;
    cpuWrite(entryAddr(0), A0);
    cpuWrite(entryAddr(5), A5);
    cpuWrite(entryAddr(255), A255);
    cpuRead(entryAddr(0), d);   check("R2 R3 entry0", 32'(d), 32'(A0));
    cpuRead(entryAddr(5), d);   check("R2 R3 entry5", 32'(d), 32'(A5));
    cpuRead(entryAddr(255), d); check("R2 R3 entry255", 32'(d), 32'(A255));
    cpuRead(12'h7FC + 12'h004, d); check("R3 unmapped", 32'(d), 0);
  endtask

  task automatic testSwap();
    logic [23:0] d; logic v;
    cpuWrite(CTRL, 24'h1);
    cpuRead(CTRL, d); check("R4 request set, status waits", 32'(d), 1);
    frame();
    cpuRead(CTRL, d); check("R5 status follows", 32'(d), 3);
    lookup(8'd5, 1, 24'h0, d, v);
    check("R6 lookup5", 32'(d), 32'(A5)); check("R6 valid", 32'(v), 1);
    @(negedge clk); check("R6 valid drops", 32'(rgbValid), 0);
    lookup(8'd255, 1, 24'h0, d, v); check("R6 lookup255", 32'(d), 32'(A255));
  endtask

  task automatic testHiddenWrite();
    logic [23:0] d; logic v;
    cpuWrite(entryAddr(5), B5);
    lookup(8'd5, 1, 24'h0, d, v); check("R2 display untouched", 32'(d), 32'(A5));
    cpuRead(entryAddr(5), d); check("R3 hidden readback", 32'(d), 32'(B5));
    frame();
    cpuRead(CTRL, d); check("R5 idle frame control", 32'(d), 3);
    lookup(8'd5, 1, 24'h0, d, v); check("R5 idle frame display", 32'(d), 32'(A5));
  endtask

  task automatic testBypass();
    logic [23:0] d; logic v;
    lookup(8'd5, 0, 24'hABCDEF, d, v);
    check("R7 bypass", 32'(d), 32'hABCDEF); check("R7 valid", 32'(v), 1);
  endtask

  task automatic testCollide();
    logic [23:0] d; logic v;
    @(negedge clk); cpuWrEn = 1; cpuAddr = CTRL; cpuWrData = 24'h0; frameStrobe = 1;
    @(negedge clk); quiet();
    cpuRead(CTRL, d); check("R8 old request used, no swap", 32'(d), 2);
    lookup(8'd5, 1, 24'h0, d, v); check("R8 display kept", 32'(d), 32'(A5));
    frame();
    cpuRead(CTRL, d); check("R5 swap back", 32'(d), 0);
    lookup(8'd5, 1, 24'h0, d, v); check("R5 bank0 shown", 32'(d), 32'(B5));
    cpuWrite(CTRL, 24'h2);
    cpuRead(CTRL, d); check("R4 status not writable", 32'(d), 0);
  endtask

  task automatic testSwapWrite();
    logic [23:0] d; logic v;
    cpuWrite(CTRL, 24'h1);
    @(negedge clk);
    cpuWrEn = 1; cpuAddr = entryAddr(7); cpuWrData = C7; frameStrobe = 1;
    pixValid = 1; pixIdx = 8'd5; lutEnable = 1;
    @(negedge clk); quiet();
    check("R10 lookup at swap uses old bank", 32'(rgbOut), 32'(B5));
    cpuRead(CTRL, d); check("R5 swap done", 32'(d), 3);
    lookup(8'd7, 1, 24'h0, d, v); check("R9 write at swap shown", 32'(d), 32'(C7));
    lookup(8'd5, 1, 24'h0, d, v); check("R9 bank1 shown", 32'(d), 32'(A5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLoadHidden();
    testSwap();
    testHiddenWrite();
    testBypass();
    testCollide();
    testSwapWrite();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule